// File: doc/BRIEF.md
# Programmable Aperture Address Remapper

This block sits between one request source and a small set of target ports. The top address bits split the address space into equal apertures. Each aperture has a table entry with two fields: a target code and a replacement value for those top bits. A request is routed to the port the code names. The low address bits pass through unchanged, and the top bits are swapped for the stored value. A region can therefore be moved to a new place as well as sent to a port. Several apertures may name the same port, so one target can appear at more than one place in the address space.

The table is filled through a plain write port before traffic starts, one entry per cycle. After reset every entry is empty, so every request fails until software writes the table. A request that lands in an empty aperture, or in one with an undefined code, is refused with a decode error and reaches no port.

Requests use valid/ready. The translation is combinational, so the request and the selected port handshake in the same cycle. `req_ready` follows the `slv_ready` of the selected port. While that port holds ready low, the source must hold `req_valid` and `req_addr` steady, and the block keeps the same port selected. A request that ends in a decode error is accepted at once: `req_ready` is high and `err_valid` pulses for that single cycle.

Top module: `amap_remap`

## Requirements
- R1: The aperture index is `req_addr[31:28]`, giving sixteen apertures. Each aperture has its own entry with a 3-bit target code and a 4-bit replacement nibble.
- R2: For a request to a mapped aperture, `slv_addr` is the entry's nibble in bits [31:28`]`, followed by `req_addr[27:0]` unchanged.
- R3: The target codes map to ports as follows: 1 selects `slv_valid[0]`, 2 selects `slv_valid[1]`, 3 selects `slv_valid[2]` and 4 selects `slv_valid[3]`. At most one `slv_valid` bit is ever high.
- R4: A request whose entry holds code 0 or a code from 5 to 7 raises `err_valid` together with `req_ready` in the same cycle. In that case every `slv_valid` bit stays low.
- R5: After reset every entry holds code 0, so every request gets a decode error until the table is written.
- R6: A write with `cfg_we` high updates entry `cfg_idx` at the clock edge. A request in the same cycle still sees the old entry, and the new entry applies from the next cycle.
- R7: While the selected port's `slv_ready` is low, `req_ready` is low and the same `slv_valid` bit stays asserted. When that ready rises, `req_ready` rises in the same cycle.
- R8: Two apertures may name the same port with the same nibble, so the same target addresses are reachable from both.
- R9: With `req_valid` low, all `slv_valid` bits and `err_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write one table entry this cycle |
| cfg_idx | input | 4 | Aperture index to write |
| cfg_sel | input | 3 | Target code to store |
| cfg_nib | input | 4 | Replacement top nibble to store |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | 32 | Request address |
| slv_valid | output | 4 | One-hot valid per target port |
| slv_ready | input | 4 | Ready per target port |
| slv_addr | output | 32 | Translated address |
| err_valid | output | 1 | Decode error for the current request |

## Verification
The hardest case to reach from the ports is a table write and a request to the same aperture in the same cycle. A correct design must show the old entry before the clock edge and the new one after it. The bench drives the write and the request together on the falling edge. It samples the outputs before the next rising edge and again after it, without changing the request. Back-pressure is checked the same way: the request is held while the selected port's ready is low and then released.

// File: rtl/amap_pkg.sv
package amap_pkg;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 4;
  localparam int SEL_W  = 3;
  localparam int NIB_W  = IDX_W;
  localparam int LOW_W  = ADDR_W - IDX_W;
  localparam int NAPER  = 1 << IDX_W;

  typedef struct packed {
    logic [SEL_W-1:0] code;
    logic [NIB_W-1:0] nib;
  } aper_entry_t;
endpackage

// File: rtl/amap_table.sv
module amap_table
  import amap_pkg::*;
#(
  parameter int N_ENT = NAPER
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  aper_entry_t       wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output aper_entry_t       rd_data
);
  aper_entry_t tbl [N_ENT];

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        tbl[i] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(i)))
        tbl[i] <= wr_data;
    end
  end

  assign rd_data = tbl[rd_idx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(rst_n)) |-> (tbl[$past(wr_idx)] == $past(wr_data))); // R6
endmodule

// File: rtl/amap_decode.sv
module amap_decode
  import amap_pkg::*;
#(
  parameter int NPORT = 4
) (
  input  logic [SEL_W-1:0] code,
  output logic [NPORT-1:0] hit,
  output logic             miss
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign hit[p] = (code == SEL_W'(p + 1));
  end
  assign miss = ~|hit;

  always_comb begin
    AST_HIT_ONEHOT: assert ($onehot0(hit)); // R3
  end
endmodule

// File: rtl/amap_xlate.sv
module amap_xlate
  import amap_pkg::*;
(
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [NIB_W-1:0]  nib,
  output logic [ADDR_W-1:0] out_addr
);
  assign out_addr = {nib, in_addr[LOW_W-1:0]};
endmodule

// File: rtl/amap_remap.sv
module amap_remap
  import amap_pkg::*;
#(
  parameter int NPORT = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [IDX_W-1:0]      cfg_idx,
  input  logic [SEL_W-1:0]      cfg_sel,
  input  logic [NIB_W-1:0]      cfg_nib,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  output logic [NPORT-1:0]      slv_valid,
  input  logic [NPORT-1:0]      slv_ready,
  output logic [ADDR_W-1:0]     slv_addr,
  output logic                  err_valid
);
  aper_entry_t       wr_data, ent;
  logic [NPORT-1:0]  hit;
  logic              miss;

  assign wr_data.code = cfg_sel;
  assign wr_data.nib  = cfg_nib;

  amap_table #(.N_ENT(NAPER)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx),
    .wr_data(wr_data), .rd_idx(req_addr[ADDR_W-1 -: IDX_W]), .rd_data(ent)
  );

  amap_decode #(.NPORT(NPORT)) u_decode (
    .code(ent.code), .hit(hit), .miss(miss)
  );

  amap_xlate u_xlate (
    .in_addr(req_addr), .nib(ent.nib), .out_addr(slv_addr)
  );

  assign slv_valid = req_valid ? hit : '0;
  assign err_valid = req_valid & miss;
  assign req_ready = miss | (|(hit & slv_ready));

  AST_ERR_NO_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (slv_valid == '0) && req_ready); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (slv_valid == '0) && !err_valid); // R9
  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_valid != '0) |-> (slv_addr[LOW_W-1:0] == req_addr[LOW_W-1:0])); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !cfg_we && $stable(req_addr)) |=>
      (req_valid && $stable(req_addr) && !$past(cfg_we)) |-> $stable(slv_valid)); // R7
  AST_RANGE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ent.code != '0 && ent.code <= SEL_W'(NPORT)) |-> !err_valid); // R3
endmodule

// File: tb/amap_remap_bench.sv
module amap_remap_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [2:0]  cfg_sel;
  logic [3:0]  cfg_nib;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic [3:0]  slv_valid;
  logic [3:0]  slv_ready;
  logic [31:0] slv_addr;
  logic        err_valid;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  amap_remap u_amap_remap (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_nib(cfg_nib), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .slv_valid(slv_valid),
    .slv_ready(slv_ready), .slv_addr(slv_addr), .err_valid(err_valid)
  );

  // addr, expected one-hot valid, expected addr, expected err
  localparam int NV = 10;
  localparam logic [68:0] VEC [NV] = '{
    {32'hF123_4567, 4'b0001, 32'hF123_4567, 1'b0},  // R3 code1
    {32'hE000_0010, 4'b1000, 32'h0000_0010, 1'b0},  // R2 relocate
    {32'hD0AB_CDEF, 4'b0010, 32'hD0AB_CDEF, 1'b0},  // R3 code2
    {32'hC000_0000, 4'b0000, 32'h0000_0000, 1'b1},  // R4 code0
    {32'h1FFF_FFFC, 4'b0100, 32'h0FFF_FFFC, 1'b0},  // R8 alias
    {32'h0FFF_FFFC, 4'b0100, 32'h0FFF_FFFC, 1'b0},  // R8 alias
    {32'h7000_0004, 4'b0000, 32'h0000_0000, 1'b1},  // R4 code5
    {32'h6000_0004, 4'b0000, 32'h0000_0000, 1'b1},  // R4 code7
    {32'h9ABC_0000, 4'b0001, 32'h9ABC_0000, 1'b0},  // R1 aperture 9
    {32'h5555_5555, 4'b1000, 32'hA555_5555, 1'b0}   // R1 aperture 5
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [2:0] s, input logic [3:0] n);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = i; cfg_sel = s; cfg_nib = n;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_sel = '0; cfg_nib = '0;
    req_valid = 1'b0; req_addr = '0; slv_ready = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5: empty table after reset
    for (int a = 0; a < 16; a += 5) begin
      @(negedge clk);
      req_valid = 1'b1; req_addr = {a[3:0], 28'h0000123};
      #1;
      chk("R5 err after reset", {63'd0, err_valid}, 64'd1);
      chk("R5 no port after reset", {60'd0, slv_valid}, 64'd0);
    end
    req_valid = 1'b0;

    // program the table
    wr(4'hF, 3'd1, 4'hF); wr(4'hE, 3'd4, 4'h0); wr(4'hD, 3'd2, 4'hD);
    wr(4'hB, 3'd1, 4'hB); wr(4'hA, 3'd1, 4'hA); wr(4'h9, 3'd1, 4'h9);
    wr(4'h8, 3'd1, 4'h8); wr(4'h1, 3'd3, 4'h0); wr(4'h0, 3'd3, 4'h0);
    wr(4'h7, 3'd5, 4'h3); wr(4'h6, 3'd7, 4'h1); wr(4'h5, 3'd4, 4'hA);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      req_valid = 1'b1; req_addr = VEC[v][68:37];
      #1;
      chk("R3 valid", {60'd0, slv_valid}, {60'd0, VEC[v][36:33]});
      chk("R4 err", {63'd0, err_valid}, {63'd0, VEC[v][0]});
      chk("R4 ready", {63'd0, req_ready}, 64'd1);
      if (!VEC[v][0]) chk("R2 addr", {32'd0, slv_addr}, {32'd0, VEC[v][32:1]});
    end

    // R9: idle
    @(negedge clk);
    req_valid = 1'b0; req_addr = 32'hF000_0000;
    #1;
    chk("R9 idle valid", {60'd0, slv_valid}, 64'd0);
    chk("R9 idle err", {63'd0, err_valid}, 64'd0);

    // R7: back-pressure on port 2
    @(negedge clk);
    slv_ready = 4'b1011; req_valid = 1'b1; req_addr = 32'h0000_0040;
    #1;
    chk("R7 stall ready", {63'd0, req_ready}, 64'd0);
    chk("R7 stall valid", {60'd0, slv_valid}, 64'b0100);
    @(negedge clk);
    #1;
    chk("R7 held valid", {60'd0, slv_valid}, 64'b0100);
    slv_ready = 4'b1111;
    #1;
    chk("R7 release ready", {63'd0, req_ready}, 64'd1);

    // R6: write and request to aperture 12 in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'hC; cfg_sel = 3'd3; cfg_nib = 4'h5;
    req_valid = 1'b1; req_addr = 32'hC000_0ABC;
    #1;
    chk("R6 old entry err", {63'd0, err_valid}, 64'd1);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk("R6 new entry valid", {60'd0, slv_valid}, 64'b0100);
    chk("R6 new entry addr", {32'd0, slv_addr}, 64'h5000_0ABC);
    chk("R6 new entry err", {63'd0, err_valid}, 64'd0);

    @(negedge clk);
    req_valid = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule